// File: doc/BRIEF.md
# Write-Only I2C Control Register Slave

This block is an I2C slave receiver that fills a bank of five 8-bit control registers. SCL and SDA are brought into the system clock domain through a two-stage synchronizer and then oversampled, and START and STOP conditions are detected from the sampled waveforms. Each write transfer has three bytes. The first is a 7-bit address with R/W = 0. The second is a sub-address byte whose low three bits pick a register. The third is the data byte. The slave acknowledges every accepted byte by asserting an open-drain enable that pulls SDA low during the ninth clock.

The block has no read path. To write several registers, the master sends several three-byte transfers and links them with repeated STARTs. The register contents leave the block as decoded control fields. A one-cycle strobe marks each committed write so that neighbouring logic can react to it.

The five high address bits are fixed by a parameter, which defaults to 5'b10011. The two low address bits come from strap pins, so four of these slaves can share one bus.

Top module: `i2c_wr_regs`

## Requirements
- R1: After reset the registers hold these values: register 0 = 8'hFF, register 1 = 8'hFF, register 2 = 8'h90, register 3 = 8'h00, register 4 = 8'h00.
- R2: The slave accepts an address byte only when its upper seven bits equal {DEV_HI, addr_sel} and bit 0 (R/W) is 0. For an accepted address, `sda_oe` is high while SCL is high in the ninth clock.
- R3: If the address does not match, or if R/W is 1, the slave gives no ACK. It then ignores every byte up to the next START, and no register changes.
- R4: After an accepted address, the slave acknowledges the sub-address byte and the data byte. Bits 2:0 of the sub-address byte select the register, and the data byte is written to that register.
- R5: A sub-address that selects register 5, 6 or 7 is acknowledged. The data byte after it is also acknowledged, but it is discarded and no strobe is issued.
- R6: The register write happens on the rising SCL of the data byte's ACK clock. At the same time `wr_strobe` is high for exactly one system clock, and `wr_index` holds the register number.
- R7: Transfers linked by repeated STARTs with no STOP between them each write their own register.
- R8: A START or a STOP that arrives in the middle of a byte aborts the transfer and leaves all registers unchanged.
- R9: The output fields are decoded from fixed bit positions, as follows:
  - Register 0 is `att_left`.
  - Register 1 is `att_right`.
  - Register 2: `out_mode` = bits 7:4, `word_len` = bits 3:2, `deemph` = bit 1, `mute` = bit 0.
  - Register 3: `rate_grp` = bits 7:6, `rate_mult` = bits 5:4, `clk256` = bit 3, `att_common` = bit 2, `lr_swap` = bit 1, `i2s_fmt` = bit 0.
  - Register 4: `dac_off` = bit 2, `zero_mute` = bit 1, `att_load` = bit 0.
- R10: A fourth byte after a data byte gets no ACK and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | When high, pulls SDA low (ACK) |
| addr_sel | input | 2 | Strap pins for the two low address bits |
| att_left | output | 8 | Left attenuation code (register 0) |
| att_right | output | 8 | Right attenuation code (register 1) |
| out_mode | output | 4 | Output routing mode |
| word_len | output | 2 | Serial word-length select |
| deemph | output | 1 | De-emphasis enable |
| mute | output | 1 | Soft mute enable |
| rate_grp | output | 2 | Sample-rate family select |
| rate_mult | output | 2 | Sample-rate multiplier select |
| clk256 | output | 1 | Selects the 256x system clock |
| att_common | output | 1 | Apply the left attenuation to both channels |
| lr_swap | output | 1 | Word-clock polarity swap |
| i2s_fmt | output | 1 | Selects the I2S framing format |
| dac_off | output | 1 | Converter disable |
| zero_mute | output | 1 | Zero-detect mute enable |
| att_load | output | 1 | Attenuation load enable |
| wr_strobe | output | 1 | One-cycle pulse on each committed write |
| wr_index | output | 3 | Register number of the last committed write |

## Verification
The bench goes after the corner cases that a careless decoder gets wrong:
- **Wrong address or read request.** The bench sends an address for a different strap setting, and also the correct address with R/W = 1. A slave that checks only part of the address, or that ignores the R/W bit, would ACK these and would write the data bytes that follow.
- **Unused sub-address.** A slave that lets index 6 alias onto a real register would corrupt register 2 or register 4.
- **Aborted bytes.** A START or a STOP in the middle of a data byte would leave a half-shifted byte in a register if the slave committed early or failed to reset its bit count.
- **Extra byte.** A fourth byte would be written a second time if the slave looped back into the data phase.
- **Strap change.** The strap pins are changed between transfers to show that matching follows them.

// File: rtl/i2c_wr_regs.sv
module i2c_wr_regs #(
  parameter logic [4:0] DEV_HI = 5'b10011,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] addr_sel,
  output logic [7:0] att_left,
  output logic [7:0] att_right,
  output logic [3:0] out_mode,
  output logic [1:0] word_len,
  output logic       deemph,
  output logic       mute,
  output logic [1:0] rate_grp,
  output logic [1:0] rate_mult,
  output logic       clk256,
  output logic       att_common,
  output logic       lr_swap,
  output logic       i2s_fmt,
  output logic       dac_off,
  output logic       zero_mute,
  output logic       att_load,
  output logic       wr_strobe,
  output logic [2:0] wr_index
);
  localparam int NREG = 5;
  localparam logic [2:0] LAST = 3'(NREG - 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_SUB, S_DATA} phase_t;

  function automatic logic [7:0] dflt(int i);
    return (i < 2) ? 8'hFF : (i == 2) ? 8'h90 : 8'h00;
  endfunction

  logic [SYNC:0] scl_s, sda_s;
  phase_t        phase;
  logic [3:0]    cnt;
  logic          in_ack;
  logic [7:0]    sh;
  logic [2:0]    idx;
  logic [7:0]    regs [NREG];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[SYNC-1:0], scl_i};
      sda_s <= {sda_s[SYNC-1:0], sda_i};
    end

  wire scl_q = scl_s[SYNC-1];
  wire scl_p = scl_s[SYNC];
  wire sda_q = sda_s[SYNC-1];
  wire sda_p = sda_s[SYNC];
  wire scl_rise = scl_q & ~scl_p;
  wire scl_fall = ~scl_q & scl_p;
  wire start_c  = scl_q & scl_p & sda_p & ~sda_q;
  wire stop_c   = scl_q & scl_p & ~sda_p & sda_q;
  wire ack_ok   = (phase == S_ADDR) ? (sh == {DEV_HI, addr_sel, 1'b0}) : 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase     <= S_IDLE;
      cnt       <= '0;
      in_ack    <= 1'b0;
      sda_oe    <= 1'b0;
      sh        <= '0;
      idx       <= '0;
      wr_strobe <= 1'b0;
      wr_index  <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= dflt(i);
    end else begin
      wr_strobe <= 1'b0;
      if (start_c || stop_c) begin
        phase  <= start_c ? S_ADDR : S_IDLE;
        cnt    <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (phase != S_IDLE) begin
        if (scl_rise) begin
          if (in_ack) begin
            if (phase == S_DATA && sda_oe && idx <= LAST) begin
              regs[idx] <= sh;
              wr_strobe <= 1'b1;
              wr_index  <= idx;
            end
          end else if (cnt != 4'd8) begin
            sh  <= {sh[6:0], sda_q};
            cnt <= cnt + 4'd1;
          end
        end else if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            sda_oe <= 1'b0;
            cnt    <= '0;
            if (!sda_oe) phase <= S_IDLE;
            else case (phase)
              S_ADDR:  phase <= S_SUB;
              S_SUB:   begin phase <= S_DATA; idx <= sh[2:0]; end
              default: phase <= S_IDLE;
            endcase
          end else if (cnt == 4'd8) begin
            in_ack <= 1'b1;
            sda_oe <= ack_ok;
          end
        end
      end
    end

  assign att_left  = regs[0];
  assign att_right = regs[1];
  assign {out_mode, word_len, deemph, mute} = regs[2];
  assign {rate_grp, rate_mult, clk256, att_common, lr_swap, i2s_fmt} = regs[3];
  assign {dac_off, zero_mute, att_load} = regs[4][2:0];

  logic [8*NREG-1:0] flat;
  always_comb
    for (int i = 0; i < NREG; i++) flat[8*i +: 8] = regs[i];

  p_strobe_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);
  p_regs_need_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flat) |-> wr_strobe);
  p_strobe_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> wr_index <= LAST);
  p_ack_on_low_scl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q);
  p_idle_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == S_IDLE) |-> !sda_oe);
endmodule

// File: tb/test_i2c_wr_regs.sv
module test_i2c_wr_regs;
  localparam int Q = 10;
  localparam logic [4:0] HI = 5'b10011;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] addr_sel = 2'b01;
  logic       sda_oe, sda_bus;
  logic [7:0] att_left, att_right;
  logic [3:0] out_mode;
  logic [1:0] word_len, rate_grp, rate_mult;
  logic       deemph, mute, clk256, att_common, lr_swap, i2s_fmt;
  logic       dac_off, zero_mute, att_load, wr_strobe;
  logic [2:0] wr_index;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_wr_regs i_i2c_wr_regs (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .att_left(att_left), .att_right(att_right),
    .out_mode(out_mode), .word_len(word_len), .deemph(deemph), .mute(mute),
    .rate_grp(rate_grp), .rate_mult(rate_mult), .clk256(clk256),
    .att_common(att_common), .lr_swap(lr_swap), .i2s_fmt(i2s_fmt),
    .dac_off(dac_off), .zero_mute(zero_mute), .att_load(att_load),
    .wr_strobe(wr_strobe), .wr_index(wr_index));

  int vectors = 0, miscompares = 0, quiet = 0, n_strobe = 0, last_idx = -1;
  bit cmp_en = 1'b0, done = 1'b0;
  logic [7:0] exp_r [5] = '{8'hFF, 8'hFF, 8'h90, 8'h00, 8'h00};

  task automatic chk(bit ok, string req, int act, int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (cmp_en && quiet >= 5) begin
      chk(att_left == exp_r[0], "R4 R9 reg0", att_left, exp_r[0]);
      chk(att_right == exp_r[1], "R4 R9 reg1", att_right, exp_r[1]);
      chk({out_mode, word_len, deemph, mute} == exp_r[2], "R4 R9 reg2",
          {out_mode, word_len, deemph, mute}, exp_r[2]);
      chk({rate_grp, rate_mult, clk256, att_common, lr_swap, i2s_fmt} == exp_r[3],
          "R4 R9 reg3", {rate_grp, rate_mult, clk256, att_common, lr_swap, i2s_fmt}, exp_r[3]);
      chk({dac_off, zero_mute, att_load} == exp_r[4][2:0], "R4 R9 reg4",
          {dac_off, zero_mute, att_load}, exp_r[4][2:0]);
    end
    quiet++;
    if (wr_strobe) begin
      n_strobe++;
      last_idx = wr_index;
    end
  end

  task automatic drv(logic c, logic d);
    @(negedge clk);
    scl_m = c; sda_m = d; quiet = 0;
    repeat (Q - 1) @(negedge clk);
  endtask

  task automatic start_c();
    drv(1'b0, 1'b1); drv(1'b1, 1'b1); drv(1'b1, 1'b0); drv(1'b0, 1'b0);
  endtask

  task automatic stop_c();
    drv(1'b0, 1'b0); drv(1'b1, 1'b0); drv(1'b1, 1'b1);
  endtask

  task automatic send_bit(logic b);
    drv(1'b0, b); drv(1'b1, b); drv(1'b0, b);
  endtask

  task automatic send_byte(logic [7:0] b, int cidx, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    drv(1'b0, 1'b1);
    @(negedge clk);
    scl_m = 1'b1; sda_m = 1'b1; quiet = 0;
    if (cidx >= 0) exp_r[cidx] = b;
    repeat (Q - 1) @(negedge clk);
    acked = (sda_bus == 1'b0);
    drv(1'b0, 1'b1);
  endtask

  task automatic xfer(logic [6:0] a7, logic rw, logic [7:0] sub, logic [7:0] data,
                      bit ok, string req);
    bit a;
    start_c();
    send_byte({a7, rw}, -1, a);
    chk(a == ok, {req, " addr ack"}, a, ok);
    send_byte(sub, -1, a);
    chk(a == ok, {req, " sub ack"}, a, ok);
    send_byte(data, (ok && sub[2:0] < 3'd5) ? int'(sub[2:0]) : -1, a);
    chk(a == ok, {req, " data ack"}, a, ok);
  endtask

  initial begin
    bit a;
    int s0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: literal defaults, independent of the model array
    chk(att_left == 8'hFF, "R1 reg0", att_left, 8'hFF);
    chk(att_right == 8'hFF, "R1 reg1", att_right, 8'hFF);
    chk({out_mode, word_len, deemph, mute} == 8'h90, "R1 reg2",
        {out_mode, word_len, deemph, mute}, 8'h90);
    chk({rate_grp, rate_mult, clk256, att_common, lr_swap, i2s_fmt} == 8'h00, "R1 reg3",
        {rate_grp, rate_mult, clk256, att_common, lr_swap, i2s_fmt}, 8'h00);
    chk({dac_off, zero_mute, att_load} == 3'b000, "R1 reg4",
        {dac_off, zero_mute, att_load}, 0);
    chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    cmp_en = 1'b1;

    // R2 R4 R6: single write to register 0
    xfer({HI, 2'b01}, 1'b0, 8'h00, 8'h3C, 1'b1, "R2");
    stop_c();
    chk(n_strobe == 1, "R6 strobe count", n_strobe, 1);
    chk(last_idx == 0, "R6 strobe index", last_idx, 0);

    // R7: chained by repeated START
    xfer({HI, 2'b01}, 1'b0, 8'h02, 8'hA6, 1'b1, "R7");
    xfer({HI, 2'b01}, 1'b0, 8'h03, 8'h5B, 1'b1, "R7");
    xfer({HI, 2'b01}, 1'b0, 8'h04, 8'h07, 1'b1, "R7");
    xfer({HI, 2'b01}, 1'b0, 8'h01, 8'h81, 1'b1, "R7");
    stop_c();
    chk(n_strobe == 5, "R7 strobe count", n_strobe, 5);
    chk(last_idx == 1, "R7 strobe index", last_idx, 1);
    // R9: spot checks of field positions
    chk(out_mode == 4'hA, "R9 out_mode", out_mode, 4'hA);
    chk(word_len == 2'b01, "R9 word_len", word_len, 1);
    chk(rate_grp == 2'b01 && rate_mult == 2'b01, "R9 rate", {rate_grp, rate_mult}, 4'b0101);
    chk(clk256 && !att_common && lr_swap && i2s_fmt, "R9 reg3 bits",
        {clk256, att_common, lr_swap, i2s_fmt}, 4'b1011);
    chk(dac_off && zero_mute && att_load, "R9 reg4 bits", {dac_off, zero_mute, att_load}, 7);

    // R3: wrong address, then read request
    s0 = n_strobe;
    xfer({HI, 2'b00}, 1'b0, 8'h00, 8'h11, 1'b0, "R3 mismatch");
    stop_c();
    xfer({HI, 2'b01}, 1'b1, 8'h00, 8'h22, 1'b0, "R3 read");
    stop_c();
    chk(n_strobe == s0, "R3 no strobe", n_strobe, s0);

    // R5: unused register index
    xfer({HI, 2'b01}, 1'b0, 8'h06, 8'h44, 1'b1, "R5");
    stop_c();
    chk(n_strobe == s0, "R5 no strobe", n_strobe, s0);

    // R8: START mid data byte, then STOP mid data byte
    start_c();
    send_byte({HI, 2'b01, 1'b0}, -1, a);
    send_byte(8'h00, -1, a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    start_c();
    stop_c();
    start_c();
    send_byte({HI, 2'b01, 1'b0}, -1, a);
    send_byte(8'h03, -1, a);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    stop_c();
    repeat (8) @(negedge clk);
    chk(n_strobe == s0, "R8 no strobe", n_strobe, s0);
    chk(att_left == 8'h3C, "R8 reg0 kept", att_left, 8'h3C);

    // R10: fourth byte not acknowledged
    xfer({HI, 2'b01}, 1'b0, 8'h02, 8'h55, 1'b1, "R10");
    send_byte(8'hAA, -1, a);
    chk(a == 1'b0, "R10 extra byte ack", a, 0);
    stop_c();
    chk(n_strobe == s0 + 1, "R10 strobe count", n_strobe, s0 + 1);

    // R2: strap change
    addr_sel = 2'b10;
    repeat (4) @(negedge clk);
    xfer({HI, 2'b01}, 1'b0, 8'h03, 8'hEE, 1'b0, "R2 old strap");
    stop_c();
    xfer({HI, 2'b10}, 1'b0, 8'h03, 8'hC4, 1'b1, "R2 new strap");
    stop_c();
    chk(last_idx == 3, "R6 index after strap", last_idx, 3);
    repeat (10) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule